// File: doc/BRIEF.md
# Weekly Time-of-Day Alarm Matcher

This block raises an alarm on chosen days of the week at a programmed hour, minute and second. Software writes an alarm time and a set of day enables through a small register port. A running real-time clock supplies its current time word, with the weekday in the top bits, and a one-cycle strobe each second. On each strobe the block compares the clock's time of day with the alarm time. If they are equal and the clock's weekday is one of the enabled days, the block latches a pending flag for that day.

Each day has its own pending flag. Software clears a flag by writing a 1 to its bit. The interrupt output is high while any flag is set. The block does not keep time itself, and it has no bus bridge.

Register and time word layout: the seconds are in bits 5:0, the minutes in bits 13:8 and the hours in bits 20:16. In the clock word the weekday code is in bits 31:29. Code 4 is Friday, 5 is Saturday and 6 is Sunday. The register addresses are 0 for the alarm time, 1 for the day enables, 2 for the pending flags and 3 for an unmapped address.

Top module: `weekly_alarm_matcher`

## Requirements
- R1: After reset the alarm time, the day enables and the pending flags all read as zero, and `irq` is low.
- R2: A write to address 0 stores the seconds (bits 5:0), minutes (bits 13:8) and hours (bits 20:16). A read returns those fields, and every other bit reads as zero.
- R3: A write to address 1 stores the day enables in bits 6:0, where bit n enables day code n and 1 means enabled. The other bits read as zero. The enables change only on a write to address 1.
- R4: On a cycle with `tick_1s` high, pending bit n is set when enable n is 1, the clock's hour, minute and second equal the alarm's, and the weekday field (bits 31:29) equals n. At most one bit is set per tick, and bits already set stay set.
- R5: No pending bit becomes set on a cycle without `tick_1s`.
- R6: No bit is set for a disabled day, for a day other than the clock's weekday, or when the weekday code is 7.
- R7: The clock word's bits outside the time fields and the weekday field (bits 7:6, 15:14 and 28:21) do not affect the comparison.
- R8: Writing to address 2 clears each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R9: If a bit is set by a match in the same cycle that a write clears it, the set wins.
- R10: `irq` is high exactly when at least one pending bit is set.
- R11: Writes to address 3 change no state, and address 3 reads as zero. A write to address 2 never sets a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_1s | input | 1 | One-cycle strobe at each second |
| rtc_time | input | 32 | Clock word: weekday, hours, minutes, seconds |
| irq | output | 1 | High while any pending bit is set |

## Verification
The bench builds the block with its default of seven days and the fixed 3-bit weekday field. This leaves code 7 as a weekday value that names no day, so the bench can check that it never sets a flag. With all seven enables writable, the bench can set flags for two days one after the other and check that they accumulate. It also drives a tick and a clearing write in the same cycle to check that the set wins. Finally, it sets every reserved bit of the clock word on a matching tick to show that those bits play no part in the match.

// File: rtl/wkal_pkg.sv
package wkal_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HR_W    = 5;
  localparam int DAY_W   = 3;
  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = 8;
  localparam int HR_LSB  = 16;
  localparam int DAY_LSB = DATA_W - DAY_W;
  localparam int KEY_W   = SEC_W + MIN_W + HR_W;

  localparam logic [ADDR_W-1:0] A_ALARM = 2'd0;
  localparam logic [ADDR_W-1:0] A_EN    = 2'd1;
  localparam logic [ADDR_W-1:0] A_PEND  = 2'd2;

  typedef logic [KEY_W-1:0] tkey_t;

  // Pack the valid time fields of a word into one compare key.
  function automatic tkey_t time_key(input logic [DATA_W-1:0] w);
    return {w[HR_LSB +: HR_W], w[MIN_LSB +: MIN_W], w[SEC_LSB +: SEC_W]};
  endfunction

  // Spread a key back into register layout, reserved bits zero.
  function automatic logic [DATA_W-1:0] key_word(input tkey_t k);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEC_LSB +: SEC_W] = k[0 +: SEC_W];
    w[MIN_LSB +: MIN_W] = k[SEC_W +: MIN_W];
    w[HR_LSB +: HR_W]   = k[SEC_W + MIN_W +: HR_W];
    return w;
  endfunction

  function automatic logic [DAY_W-1:0] day_of(input logic [DATA_W-1:0] w);
    return w[DAY_LSB +: DAY_W];
  endfunction
endpackage

// File: rtl/wkal_regs.sv
module wkal_regs
  import wkal_pkg::*;
#(
  parameter int NUM_DAYS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_DAYS-1:0] pend,
  output tkey_t               alarm_key,
  output logic [NUM_DAYS-1:0] en,
  output logic [NUM_DAYS-1:0] clr,
  output logic [DATA_W-1:0]   rdata
);
  tkey_t               key_q;
  logic [NUM_DAYS-1:0] en_q;
  logic                wr_alarm, wr_en_reg, wr_pend;
  logic                unused_wdata;

  assign wr_alarm     = wr_en && (addr == A_ALARM);
  assign wr_en_reg    = wr_en && (addr == A_EN);
  assign wr_pend      = wr_en && (addr == A_PEND);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_alarm)  key_q <= time_key(wdata);
      if (wr_en_reg) en_q  <= wdata[NUM_DAYS-1:0];
    end
  end

  assign alarm_key = key_q;
  assign en        = en_q;
  assign clr       = wr_pend ? wdata[NUM_DAYS-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      A_ALARM: rdata = key_word(key_q);
      A_EN:    rdata[NUM_DAYS-1:0] = en_q;
      A_PEND:  rdata[NUM_DAYS-1:0] = pend;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wkal_match.sv
module wkal_match
  import wkal_pkg::*;
#(
  parameter int NUM_DAYS = 7
) (
  input  logic                tick,
  input  logic [DATA_W-1:0]   rtc_time,
  input  tkey_t               alarm_key,
  input  logic [NUM_DAYS-1:0] en,
  output logic [NUM_DAYS-1:0] hit
);
  logic             key_eq;
  logic [DAY_W-1:0] day;
  logic             unused_rtc;

  assign key_eq     = (time_key(rtc_time) == alarm_key);
  assign day        = day_of(rtc_time);
  assign unused_rtc = ^rtc_time;

  for (genvar d = 0; d < NUM_DAYS; d++) begin : g_day
    assign hit[d] = tick && en[d] && key_eq && (day == DAY_W'(d));
  end
endmodule

// File: rtl/wkal_pending.sv
module wkal_pending #(
  parameter int NUM_DAYS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DAYS-1:0] hit,
  input  logic [NUM_DAYS-1:0] clr,
  output logic [NUM_DAYS-1:0] pend
);
  for (genvar d = 0; d < NUM_DAYS; d++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      pend[d] <= 1'b0;
      else if (hit[d]) pend[d] <= 1'b1;
      else if (clr[d]) pend[d] <= 1'b0;
    end
  end
endmodule

// File: rtl/weekly_alarm_matcher.sv
module weekly_alarm_matcher
  import wkal_pkg::*;
#(
  parameter int NUM_DAYS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_1s,
  input  logic [DATA_W-1:0] rtc_time,
  output logic              irq
);
  tkey_t               alarm_key;
  logic [NUM_DAYS-1:0] en_q;
  logic [NUM_DAYS-1:0] clr_vec;
  logic [NUM_DAYS-1:0] hit_vec;
  logic [NUM_DAYS-1:0] pend_q;

  wkal_regs #(.NUM_DAYS(NUM_DAYS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .pend(pend_q), .alarm_key(alarm_key),
    .en(en_q), .clr(clr_vec), .rdata(reg_rdata)
  );

  wkal_match #(.NUM_DAYS(NUM_DAYS)) u_match (
    .tick(tick_1s), .rtc_time(rtc_time), .alarm_key(alarm_key),
    .en(en_q), .hit(hit_vec)
  );

  wkal_pending #(.NUM_DAYS(NUM_DAYS)) u_pend (
    .clk(clk), .rst_n(rst_n), .hit(hit_vec), .clr(clr_vec), .pend(pend_q)
  );

  assign irq = |pend_q;
endmodule

// File: rtl/wkal_chk.sv
module wkal_chk #(
  parameter int NUM_DAYS = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                wr,
  input logic [1:0]          addr,
  input logic [NUM_DAYS-1:0] wdata_lo,
  input logic [NUM_DAYS-1:0] en,
  input logic [NUM_DAYS-1:0] hit,
  input logic [NUM_DAYS-1:0] pend
);
  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((pend & ~$past(pend)) == '0)); // R5
  AST_ONE_DAY_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> $onehot0(pend & ~$past(pend))); // R4
  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((pend & ~$past(pend) & ~$past(en)) == '0)); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd2 && !tick) |=> ((pend & $past(wdata_lo)) == '0)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pend & $past(hit)) == $past(hit))); // R9
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd1) |=> $stable(en)); // R3
endmodule

bind weekly_alarm_matcher wkal_chk #(.NUM_DAYS(NUM_DAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1s), .wr(reg_wr), .addr(reg_addr),
  .wdata_lo(reg_wdata[NUM_DAYS-1:0]), .en(en_q), .hit(hit_vec), .pend(pend_q)
);

// File: tb/weekly_alarm_matcher_tb.sv
module weekly_alarm_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_1s = 1'b0;
  logic [31:0] rtc_time = '0;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int m_sec = 0, m_min = 0, m_hr = 0, m_en = 0, m_pend = 0;

  always #10 clk = ~clk;

  weekly_alarm_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_1s(tick_1s),
    .rtc_time(rtc_time), .irq(irq)
  );

  always @(posedge clk) begin
    int setb;
    int clrb;
    int dcode;
    setb = 0;
    clrb = 0;
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_en = 0; m_pend = 0;
    end else begin
      dcode = int'(rtc_time[31:29]);
      if (tick_1s && dcode < 7 && ((m_en >> dcode) & 1) == 1 &&
          int'(rtc_time[5:0]) == m_sec && int'(rtc_time[13:8]) == m_min &&
          int'(rtc_time[20:16]) == m_hr)
        setb = 1 << dcode;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin
            m_sec = int'(reg_wdata[5:0]);
            m_min = int'(reg_wdata[13:8]);
            m_hr  = int'(reg_wdata[20:16]);
          end
          2'd1: m_en = int'(reg_wdata[6:0]);
          2'd2: clrb = int'(reg_wdata[6:0]);
          default: ;
        endcase
      end
      m_pend = (m_pend & ~clrb) | setb;
    end
  end

  // R10: irq compared against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (irq !== (m_pend != 0)) begin
        mismatched++;
        $display("FAIL R10 irq actual=%0b expected=%0b", irq, m_pend != 0);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1s = 1'b1;
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    compared++;
    if (reg_rdata !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  localparam logic [31:0] ALM = (32'd12 << 16) | (32'd34 << 8) | 32'd56;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, 32'h0, "R1"); rd(2'd1, 32'h0, "R1"); rd(2'd2, 32'h0, "R1");

    wr(2'd0, ALM | 32'hFFE0_C0C0);
    rd(2'd0, ALM, "R2");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h7F, "R3");
    wr(2'd1, 32'h08);
    rd(2'd1, 32'h08, "R3");

    rtc_time = ALM | (32'd3 << 29);
    repeat (3) @(negedge clk);
    rd(2'd2, 32'h0, "R5");
    tick();
    rd(2'd2, 32'h08, "R4");

    wr(2'd2, 32'hFFFF_FFF7);
    rd(2'd2, 32'h08, "R8");
    wr(2'd2, 32'h08);
    rd(2'd2, 32'h0, "R8");

    rtc_time = ALM | (32'd2 << 29);
    tick();
    rd(2'd2, 32'h0, "R6 disabled day");
    wr(2'd1, 32'h7F);
    rtc_time = ALM | (32'd7 << 29);
    tick();
    rd(2'd2, 32'h0, "R6 code 7");
    rtc_time = (ALM + 32'd1) | (32'd2 << 29);
    tick();
    rd(2'd2, 32'h0, "R4 time mismatch");

    rtc_time = ALM | (32'd6 << 29) | 32'h1FE0_C0C0;
    tick();
    rd(2'd2, 32'h40, "R7");

    rtc_time = ALM | (32'd6 << 29);
    @(negedge clk);
    tick_1s = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h40;
    @(negedge clk);
    tick_1s = 1'b0; reg_wr = 1'b0;
    rd(2'd2, 32'h40, "R9");
    wr(2'd2, 32'h40);
    rd(2'd2, 32'h0, "R8");

    rtc_time = ALM;
    tick();
    rtc_time = ALM | (32'd1 << 29);
    tick();
    rd(2'd2, 32'h03, "R4 two days");
    wr(2'd2, 32'h7F);
    rd(2'd2, 32'h0, "R8");

    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R11");
    rd(2'd0, ALM, "R11");
    rd(2'd1, 32'h7F, "R11");
    wr(2'd2, 32'h7F);
    rd(2'd2, 32'h0, "R11");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule